// File: doc/BRIEF.md
# Triggered Frame-Position Reset Timing Generator

This block is a raster timing generator for one display pipe. It keeps a horizontal and a vertical pixel counter, wraps them at programmable totals, and drives horizontal and vertical sync pulses over programmable inclusive windows. It can also lock its frame start to the vertical sync of another pipe. All pipes run from the same pixel clock. A source index picks one bit from a vector of peer vertical syncs. That bit is registered once, and separate rising-edge and falling-edge enables turn it into a trigger.

A trigger realigns the raster in one of two ways. Pixel mode jumps the counters at once to their end-of-frame values, so the next pixel begins a new frame. Line mode waits for the current line to finish, then restarts the vertical count at the next line, so the programmed vertical sync follows. Each mode has a sticky flag that records that its realignment took place. A combined flag reports that either one occurred. Single-cycle clear pulses reset the sticky flags. To turn the mechanism off, drive the source index to zero, clear both mode enables and pulse both clears. Selecting the master pipe is done outside this block.

Top module: `tg_frame_realign`

## Requirements
- R1: With no realignment, `h_cnt` counts 0 to `h_total`-1. At the last pixel of a line it returns to 0 and `v_cnt` steps by one. `v_cnt` returns to 0 after `v_total`-1. After reset both counters are 0.
- R2: `hsync` is high exactly when `h_cnt` lies in the inclusive window [`hs_start`, `hs_end`]. `vsync` is high exactly when `v_cnt` lies in the inclusive window [`vs_start`, `vs_end`].
- R3: `trig_src` = 0 selects a constant zero, so no trigger is produced. `trig_src` = k, with 1 ≤ k ≤ N_PEERS, selects `peer_vsync[k-1]`. The selected bit is not inverted. If the peer input changes before clock edge n, the resulting realignment takes effect at edge n+1. The outputs therefore first differ from free running after the second edge.
- R4: `rise_en` makes a 0→1 change of the selected sync a trigger. `fall_en` makes a 1→0 change a trigger. A change in the direction whose enable is low has no effect.
- R5: Pixel mode (`pixel_mode_en` = 1): on a trigger, `h_cnt` becomes `h_total` and `v_cnt` becomes `v_total` at the next edge. At the edge after that both counters are 0.
- R6: With `interlaced` = 1, pixel mode loads `v_cnt` with `v_total`-1 instead of `v_total`. The counters still reach 0,0 one edge later.
- R7: Line mode (`line_mode_en` = 1): a trigger is held pending until the last pixel of the current line. This includes a trigger that arrives in that very cycle. At that edge `h_cnt` goes to 0 and `v_cnt` goes to 0, instead of stepping.
- R8: When both modes are enabled, a trigger performs only the pixel-mode realignment. No line-mode request is queued.
- R9: `pixel_flag` sets at the edge where a pixel-mode realignment happens. `line_flag` sets at the edge where a line-mode realignment happens, even when that edge coincides with the natural frame wrap. Both flags stay set. `realigned` is high when either flag is set. Reset clears them.
- R10: A one-cycle pulse on `clr_pixel_flag` clears `pixel_flag`. A pulse on `clr_line_flag` clears `line_flag`.
- R11: A trigger for a mode whose enable is low changes neither the counters nor the flags. Dropping `line_mode_en`, or selecting source 0, cancels a pending line-mode request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_total | input | H_W | Pixels per line |
| v_total | input | V_W | Lines per frame |
| interlaced | input | 1 | Interlaced timing: pixel mode loads `v_total`-1 |
| hs_start | input | H_W | First pixel of horizontal sync |
| hs_end | input | H_W | Last pixel of horizontal sync |
| vs_start | input | V_W | First line of vertical sync |
| vs_end | input | V_W | Last line of vertical sync |
| peer_vsync | input | N_PEERS | Vertical syncs of peer pipes |
| trig_src | input | SEL_W | 0 = off, k = peer k-1 |
| rise_en | input | 1 | Trigger on rising edge |
| fall_en | input | 1 | Trigger on falling edge |
| pixel_mode_en | input | 1 | Enable immediate realignment |
| line_mode_en | input | 1 | Enable next-line realignment |
| clr_pixel_flag | input | 1 | Clear pulse for `pixel_flag` |
| clr_line_flag | input | 1 | Clear pulse for `line_flag` |
| h_cnt | output | H_W | Horizontal position |
| v_cnt | output | V_W | Vertical position |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| pixel_flag | output | 1 | Sticky: pixel-mode realignment occurred |
| line_flag | output | 1 | Sticky: line-mode realignment occurred |
| realigned | output | 1 | OR of the two sticky flags |

## Verification
The assertions watch, on every cycle, the following:
- the free-running line and frame step;
- the values loaded by a pixel-mode realignment and the zero restart of a line-mode one;
- that each flag rises only together with its own realignment;
- that a clear pulse lowers its flag;
- that a line request is dropped when its mode is off;
- that a rising-only trigger follows a fresh rise of the selected sync.

Only the bench scenarios show the properties that relate separate events:
- the two-edge latency from a peer edge;
- which peer index a source value selects;
- that a line-mode request waits for the end of the line;
- the coincident wrap that still sets the flag;
- that pixel mode wins over line mode and leaves nothing queued for the next line.

// File: rtl/tg_realign_pkg.sv
package tg_realign_pkg;
  // Which realignment the raster counter applies at the coming edge.
  typedef enum logic [1:0] {
    FORCE_NONE  = 2'd0,
    FORCE_PIXEL = 2'd1,
    FORCE_LINE  = 2'd2
  } force_e;
endpackage

// File: rtl/tg_peer_trigger.sv
module tg_peer_trigger #(
  parameter int N_PEERS = 4,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PEERS-1:0] peer_vsync,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               rise_en,
  input  logic               fall_en,
  output logic               trig
);
  logic [N_PEERS-1:0] peer_q;
  logic               sel_now;
  logic               sel_prev;
  logic               src_on;

  // One register stage per peer sync input.
  genvar g;
  generate
    for (g = 0; g < N_PEERS; g++) begin : g_peer_reg
      always_ff @(posedge clk) begin
        if (!rst_n) peer_q[g] <= 1'b0;
        else        peer_q[g] <= peer_vsync[g];
      end
    end
  endgenerate

  // Source 0 selects a constant zero; source k selects peer k-1.
  always_comb begin
    sel_now = 1'b0;
    for (int i = 0; i < N_PEERS; i++) begin
      if (src_sel == SEL_W'(i + 1)) sel_now = peer_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_prev <= 1'b0;
    else        sel_prev <= sel_now;
  end

  assign src_on = (src_sel != '0);
  assign trig   = src_on & ((rise_en & sel_now & ~sel_prev) |
                            (fall_en & ~sel_now & sel_prev));

  // A rising-only trigger must coincide with a fresh rise of the selected sync.
  assert_rise_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !fall_en) |-> $rose(sel_now));
endmodule

// File: rtl/tg_raster_counter.sv
module tg_raster_counter
  import tg_realign_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [H_W-1:0] h_total,
  input  logic [V_W-1:0] v_total,
  input  logic           interlaced,
  input  force_e         force_kind,
  input  logic [H_W-1:0] hs_start,
  input  logic [H_W-1:0] hs_end,
  input  logic [V_W-1:0] vs_start,
  input  logic [V_W-1:0] vs_end,
  output logic [H_W-1:0] h_cnt,
  output logic [V_W-1:0] v_cnt,
  output logic           hsync,
  output logic           vsync,
  output logic           line_end
);
  logic frame_end;

  assign line_end  = (h_cnt >= h_total - 1'b1);
  assign frame_end = (v_cnt >= v_total - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else begin
      unique case (force_kind)
        FORCE_PIXEL: begin
          h_cnt <= h_total;
          v_cnt <= interlaced ? (v_total - 1'b1) : v_total;
        end
        FORCE_LINE: begin
          h_cnt <= '0;
          v_cnt <= '0;
        end
        default: begin
          if (line_end) begin
            h_cnt <= '0;
            v_cnt <= frame_end ? '0 : (v_cnt + 1'b1);
          end else begin
            h_cnt <= h_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign hsync = (h_cnt >= hs_start) && (h_cnt <= hs_end);
  assign vsync = (v_cnt >= vs_start) && (v_cnt <= vs_end);

  assert_line_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !frame_end && force_kind == FORCE_NONE)
      |=> (h_cnt == '0) && (v_cnt == $past(v_cnt) + 1'b1));

  assert_pixel_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (force_kind == FORCE_PIXEL && !interlaced)
      |=> (h_cnt == $past(h_total)) && (v_cnt == $past(v_total)));

  assert_line_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_kind == FORCE_LINE) |=> (h_cnt == '0) && (v_cnt == '0));
endmodule

// File: rtl/tg_frame_realign.sv
module tg_frame_realign
  import tg_realign_pkg::*;
#(
  parameter int H_W     = 12,
  parameter int V_W     = 12,
  parameter int N_PEERS = 4,
  localparam int SEL_W  = $clog2(N_PEERS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [H_W-1:0]     h_total,
  input  logic [V_W-1:0]     v_total,
  input  logic               interlaced,
  input  logic [H_W-1:0]     hs_start,
  input  logic [H_W-1:0]     hs_end,
  input  logic [V_W-1:0]     vs_start,
  input  logic [V_W-1:0]     vs_end,
  input  logic [N_PEERS-1:0] peer_vsync,
  input  logic [SEL_W-1:0]   trig_src,
  input  logic               rise_en,
  input  logic               fall_en,
  input  logic               pixel_mode_en,
  input  logic               line_mode_en,
  input  logic               clr_pixel_flag,
  input  logic               clr_line_flag,
  output logic [H_W-1:0]     h_cnt,
  output logic [V_W-1:0]     v_cnt,
  output logic               hsync,
  output logic               vsync,
  output logic               pixel_flag,
  output logic               line_flag,
  output logic               realigned
);
  logic   trig;
  logic   line_end;
  logic   line_active;
  logic   line_pending;
  logic   do_pixel;
  logic   do_line;
  force_e force_kind;

  tg_peer_trigger #(.N_PEERS(N_PEERS), .SEL_W(SEL_W)) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .peer_vsync (peer_vsync),
    .src_sel    (trig_src),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .trig       (trig)
  );

  // Pixel mode takes precedence; line mode acts only at the last pixel of a line.
  assign line_active = line_mode_en && (trig_src != '0);
  assign do_pixel    = trig && pixel_mode_en;
  assign do_line     = line_active && line_end && !do_pixel &&
                       (line_pending || (trig && !pixel_mode_en));

  always_comb begin
    if (do_pixel)     force_kind = FORCE_PIXEL;
    else if (do_line) force_kind = FORCE_LINE;
    else              force_kind = FORCE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               line_pending <= 1'b0;
    else if (!line_active || do_pixel || do_line) line_pending <= 1'b0;
    else if (trig && !pixel_mode_en)          line_pending <= 1'b1;
  end

  tg_raster_counter #(.H_W(H_W), .V_W(V_W)) u_raster (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_total    (h_total),
    .v_total    (v_total),
    .interlaced (interlaced),
    .force_kind (force_kind),
    .hs_start   (hs_start),
    .hs_end     (hs_end),
    .vs_start   (vs_start),
    .vs_end     (vs_end),
    .h_cnt      (h_cnt),
    .v_cnt      (v_cnt),
    .hsync      (hsync),
    .vsync      (vsync),
    .line_end   (line_end)
  );

  // Sticky flags: a realignment in the same cycle as a clear keeps the flag set.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pixel_flag <= 1'b0;
      line_flag  <= 1'b0;
    end else begin
      if (do_pixel)            pixel_flag <= 1'b1;
      else if (clr_pixel_flag) pixel_flag <= 1'b0;
      if (do_line)             line_flag  <= 1'b1;
      else if (clr_line_flag)  line_flag  <= 1'b0;
    end
  end

  assign realigned = pixel_flag | line_flag;

  assert_pixel_flag_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pixel_flag) |-> $past(force_kind == FORCE_PIXEL));

  assert_line_flag_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_flag) |-> $past(force_kind == FORCE_LINE) && !$past(pixel_mode_en && trig));

  assert_clear_pixel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pixel_flag && force_kind != FORCE_PIXEL) |=> !pixel_flag);

  assert_pending_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !line_active |=> !line_pending);
endmodule

// File: tb/test_tg_frame_realign.sv
`timescale 1ns/1ps
module test_tg_frame_realign;
  localparam int HW = 12, VW = 12, NP = 4, SW = 3;
  localparam int HT = 10, VT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW-1:0] h_total = HW'(HT), hs_start = 12'd2, hs_end = 12'd3;
  logic [VW-1:0] v_total = VW'(VT), vs_start = 12'd1, vs_end = 12'd2;
  logic interlaced = 1'b0;
  logic [NP-1:0] peer_vsync = '0;
  logic [SW-1:0] trig_src = 3'd2;
  logic rise_en = 1'b1, fall_en = 1'b0;
  logic pixel_mode_en = 1'b0, line_mode_en = 1'b0;
  logic clr_pixel_flag = 1'b0, clr_line_flag = 1'b0;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic hsync, vsync, pixel_flag, line_flag, realigned;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tg_frame_realign #(.H_W(HW), .V_W(VW), .N_PEERS(NP)) i_tg_frame_realign (
    .clk(clk), .rst_n(rst_n), .h_total(h_total), .v_total(v_total),
    .interlaced(interlaced), .hs_start(hs_start), .hs_end(hs_end),
    .vs_start(vs_start), .vs_end(vs_end), .peer_vsync(peer_vsync),
    .trig_src(trig_src), .rise_en(rise_en), .fall_en(fall_en),
    .pixel_mode_en(pixel_mode_en), .line_mode_en(line_mode_en),
    .clr_pixel_flag(clr_pixel_flag), .clr_line_flag(clr_line_flag),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .hsync(hsync), .vsync(vsync),
    .pixel_flag(pixel_flag), .line_flag(line_flag), .realigned(realigned)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Free-running successor, from R1.
  function automatic void nat(input int h, input int v, output int nh, output int nv);
    if (h >= HT - 1) begin
      nh = 0;
      nv = (v >= VT - 1) ? 0 : v + 1;
    end else begin
      nh = h + 1;
      nv = v;
    end
  endfunction

  task automatic wait_at(input int th, input int tv);
    int n = 0;
    while (!(int'(h_cnt) == th && int'(v_cnt) == tv) && n < 300) begin
      step();
      n++;
    end
    chk("R1 reach position", int'(n < 300), 1);
  endtask

  // Step k cycles expecting free running and untouched flags.
  task automatic natural_steps(input string req, input int k);
    int nh, nv;
    for (int i = 0; i < k; i++) begin
      nat(int'(h_cnt), int'(v_cnt), nh, nv);
      step();
      chk({req, " h"}, int'(h_cnt), nh);
      chk({req, " v"}, int'(v_cnt), nv);
      chk({req, " flags"}, int'(realigned), 0);
    end
  endtask

  task automatic clear_flags();
    clr_pixel_flag = 1'b1;
    clr_line_flag  = 1'b1;
    step();
    clr_pixel_flag = 1'b0;
    clr_line_flag  = 1'b0;
    step();
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    step();
    chk("R1 reset h", int'(h_cnt), 0);
    chk("R1 reset v", int'(v_cnt), 0);
    chk("R9 reset flag", int'(realigned), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_free_run();
    int nh, nv;
    for (int i = 0; i < 2 * HT * VT; i++) begin
      nat(int'(h_cnt), int'(v_cnt), nh, nv);
      step();
      chk("R1 free h", int'(h_cnt), nh);
      chk("R1 free v", int'(v_cnt), nv);
      chk("R2 hsync", int'(hsync), int'(nh >= 2 && nh <= 3));
      chk("R2 vsync", int'(vsync), int'(nv >= 1 && nv <= 2));
    end
  endtask

  task automatic t_pixel(input bit ilace);
    interlaced = ilace;
    pixel_mode_en = 1'b1;
    trig_src = 3'd2;
    wait_at(4, 2);
    peer_vsync[1] = 1'b1;
    step();
    chk("R3 no effect after one edge h", int'(h_cnt), 5);
    chk("R3 no effect after one edge v", int'(v_cnt), 2);
    step();
    chk(ilace ? "R6 forced h" : "R5 forced h", int'(h_cnt), HT);
    chk(ilace ? "R6 forced v" : "R5 forced v", int'(v_cnt), ilace ? VT - 1 : VT);
    chk("R9 pixel flag", int'(pixel_flag), 1);
    chk("R9 combined flag", int'(realigned), 1);
    chk("R9 line flag idle", int'(line_flag), 0);
    step();
    chk("R5 new frame h", int'(h_cnt), 0);
    chk("R5 new frame v", int'(v_cnt), 0);
    peer_vsync[1] = 1'b0;   // falling edge, rise only enabled
    step();
    step();
    chk("R4 fall ignored h", int'(h_cnt), 2);
    chk("R4 fall ignored v", int'(v_cnt), 0);
    clr_pixel_flag = 1'b1;
    step();
    clr_pixel_flag = 1'b0;
    chk("R10 clear pixel flag", int'(pixel_flag), 0);
    chk("R10 combined after clear", int'(realigned), 0);
    interlaced = 1'b0;
    pixel_mode_en = 1'b0;
  endtask

  task automatic t_falling();
    rise_en = 1'b0; fall_en = 1'b1; pixel_mode_en = 1'b1;
    peer_vsync[1] = 1'b1;
    natural_steps("R4 rise ignored", 4);
    wait_at(3, 1);
    peer_vsync[1] = 1'b0;
    step();
    chk("R4 fall latency h", int'(h_cnt), 4);
    step();
    chk("R4 fall forced h", int'(h_cnt), HT);
    chk("R4 fall forced v", int'(v_cnt), VT);
    chk("R4 fall flag", int'(pixel_flag), 1);
    rise_en = 1'b1; fall_en = 1'b0; pixel_mode_en = 1'b0;
    clear_flags();
  endtask

  task automatic t_line();
    line_mode_en = 1'b1;
    wait_at(2, 1);
    peer_vsync[1] = 1'b1;
    while (int'(h_cnt) != HT - 1) begin
      step();
      chk("R7 wait line end v", int'(v_cnt), 1);
      chk("R7 no early flag", int'(line_flag), 0);
    end
    step();
    chk("R7 restart h", int'(h_cnt), 0);
    chk("R7 restart v", int'(v_cnt), 0);
    chk("R9 line flag", int'(line_flag), 1);
    chk("R9 combined line", int'(realigned), 1);
    chk("R9 pixel flag idle", int'(pixel_flag), 0);
    peer_vsync[1] = 1'b0;
    clear_flags();
    chk("R10 clear line flag", int'(line_flag), 0);
    // Trigger landing on the last pixel of the last line.
    wait_at(8, VT - 1);
    peer_vsync[1] = 1'b1;
    step();
    chk("R7 same-cycle h", int'(h_cnt), HT - 1);
    chk("R9 coincident no flag yet", int'(line_flag), 0);
    step();
    chk("R7 coincident wrap h", int'(h_cnt), 0);
    chk("R7 coincident wrap v", int'(v_cnt), 0);
    chk("R9 coincident wrap flag", int'(line_flag), 1);
    peer_vsync[1] = 1'b0;
    line_mode_en = 1'b0;
    clear_flags();
  endtask

  task automatic t_priority();
    pixel_mode_en = 1'b1; line_mode_en = 1'b1;
    wait_at(4, 3);
    peer_vsync[1] = 1'b1;
    step();
    step();
    chk("R8 pixel wins h", int'(h_cnt), HT);
    chk("R8 pixel flag", int'(pixel_flag), 1);
    chk("R8 no line flag", int'(line_flag), 0);
    step();
    while (int'(h_cnt) != HT - 1) step();
    step();
    chk("R8 nothing queued v", int'(v_cnt), 1);
    chk("R8 still no line flag", int'(line_flag), 0);
    peer_vsync[1] = 1'b0;
    pixel_mode_en = 1'b0; line_mode_en = 1'b0;
    clear_flags();
  endtask

  task automatic t_disabled();
    wait_at(1, 2);
    peer_vsync[1] = 1'b1;
    natural_steps("R11 modes off", 4);
    peer_vsync[1] = 1'b0;
    natural_steps("R11 modes off drop", 2);
    // Cancel a pending line request by dropping the mode.
    line_mode_en = 1'b1;
    wait_at(2, 1);
    peer_vsync[1] = 1'b1;
    step();
    step();
    line_mode_en = 1'b0;
    step();
    line_mode_en = 1'b1;
    while (int'(h_cnt) != HT - 1) step();
    step();
    chk("R11 cancelled h", int'(h_cnt), 0);
    chk("R11 cancelled v", int'(v_cnt), 2);
    chk("R11 cancelled flag", int'(line_flag), 0);
    peer_vsync[1] = 1'b0;
    line_mode_en = 1'b0;
    step();
    step();
  endtask

  task automatic t_source();
    pixel_mode_en = 1'b1;
    trig_src = 3'd0;
    peer_vsync = 4'b1111;
    natural_steps("R3 source zero", 4);
    peer_vsync = 4'b0000;
    natural_steps("R3 source zero drop", 2);
    trig_src = 3'd3;
    step();
    wait_at(4, 2);
    peer_vsync[0] = 1'b1;
    natural_steps("R3 other peer", 3);
    peer_vsync[2] = 1'b1;
    step();
    chk("R3 selected peer latency h", int'(h_cnt), 8);
    step();
    chk("R3 selected peer h", int'(h_cnt), HT);
    chk("R3 selected peer flag", int'(pixel_flag), 1);
    peer_vsync = '0;
    pixel_mode_en = 1'b0;
    trig_src = 3'd2;
    clear_flags();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_free_run();
    t_pixel(1'b0);
    t_pixel(1'b1);
    t_falling();
    t_line();
    t_priority();
    t_disabled();
    t_source();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule